// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block watches the write cycles of a parallel NOR-flash style bus (address, 16-bit data, write strobe). It recognises the multi-write unlock-and-command sequences that the bus master uses to ask for flash operations. A recognised command becomes a one-cycle request pulse for the operation engine. Program requests and sector erase requests come with a latched address, and program requests also carry latched data. The decoder tracks its operating mode: read-array, autoselect or unlock-bypass. Alongside the mode it keeps a flag that marks a suspended sector erase.

The operation engine reports its state through two signals. `busy_i` is high while an operation runs, and `done_i` pulses when a sector erase has finished. Reads are combinational. In autoselect mode, a read that addresses the selected bank returns an identification word from a small fixed table. Every other read goes straight to the array read port.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode_o` is 0 (read-array), `suspended_o` is 0 and every request pulse is low.
- R2: Unlock and command matching uses only address bits A10:A0 and data bits D7:D0. All higher address and data bits are ignored.
- R3: The sequence AAh@555h, 55h@2AAh, A0h@555h, then any write produces `prog_req_o` one cycle after the fourth write. `op_addr_o` and `op_data_o` hold the full address and data of that fourth write.
- R4: The sequence unlock, 80h@555h, unlock, 10h@555h produces `chip_erase_o`. If the sixth write is instead 30h at any address, the block produces `sector_erase_o` with that address on `op_addr_o` and marks a sector erase as running.
- R5: Unlock followed by 90h@555h pulses `autosel_o`, sets `mode_o` to 1 and selects the bank in address bits [15:14]. While the mode is 1, a read in that bank returns a word chosen by address bits [7:0]: 0001h at 00h, 22A5h at 01h, 2210h at 0Eh, 2203h at 0Fh, protect bit PROT_MASK[addr[15:13]] at 02h, and 0000h at every other offset. Reads in other banks go to the array.
- R6: Outside bypass mode, a single F0h write at any address pulses `reset_o` and sets `mode_o` to 0. It leaves `suspended_o` unchanged.
- R7: A B0h write pulses `suspend_o` and sets `suspended_o` only while a sector erase is running and not already suspended. `done_i` ends the running erase. A 30h write pulses `resume_o` and clears `suspended_o` only while suspended.
- R8: A 98h write at 55h pulses `cfi_o` only in autoselect mode, or in read-array mode with no suspended erase.
- R9: Unlock followed by 20h@555h, issued from read-array mode with no suspension, sets `mode_o` to 2 (bypass). In bypass, A0h followed by any write requests a program, and 80h followed by 10h requests a chip erase.
- R10: Bypass mode is left only by 90h followed by 00h. An F0h write in bypass has no effect.
- R11: A write that does not fit the expected step aborts the partial sequence without a request and keeps the current mode.
- R12: While `busy_i` is high, every write except B0h is ignored.
- R13: Each request is high for exactly one cycle.
- R14: Outside autoselect hits, `array_rd_o` follows `rd_i` and `rdata_o` equals `array_rdata_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write cycle strobe |
| rd_i | input | 1 | Read cycle strobe |
| addr_i | input | 16 | Bus address |
| wdata_i | input | 16 | Write data |
| busy_i | input | 1 | Operation engine busy |
| done_i | input | 1 | Sector erase finished pulse |
| array_rdata_i | input | 16 | Array read data |
| array_rd_o | output | 1 | Read forwarded to the array |
| rdata_o | output | 16 | Read data to the bus |
| prog_req_o | output | 1 | Program request pulse |
| chip_erase_o | output | 1 | Chip erase request pulse |
| sector_erase_o | output | 1 | Sector erase request pulse |
| suspend_o | output | 1 | Erase suspend request pulse |
| resume_o | output | 1 | Erase resume request pulse |
| reset_o | output | 1 | Return-to-read pulse |
| autosel_o | output | 1 | Autoselect entry pulse |
| cfi_o | output | 1 | Query request pulse |
| op_addr_o | output | 16 | Latched program or sector address |
| op_data_o | output | 16 | Latched program data |
| mode_o | output | 2 | 0 read-array, 1 autoselect, 2 bypass |
| suspended_o | output | 1 | Sector erase is suspended |

## Verification
All 256 command codes are swept through the third write of a standard unlock. This shows that only 90h, 20h, A0h and 80h change the mode or advance the decoder, and that every other code falls back silently. The autoselect read path is swept over all four banks, both sector groups of a bank and all 256 offsets, with each expected word computed from the table rule. This separates the selected-bank hits from pass-through reads. Directed sequences then test the conditions that depend on the operating context: high address and data bits with noise, suspend and resume with and without a running erase, writes while busy, and the shortened bypass sequences together with the single way out of bypass.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {
    MODE_READ    = 2'd0,
    MODE_AUTOSEL = 2'd1,
    MODE_BYPASS  = 2'd2
  } mode_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PROG,
    ST_ER1, ST_ER2, ST_ER3, ST_BERASE, ST_BEXIT
  } step_e;

  typedef struct packed {
    logic prog;
    logic chip;
    logic sect;
    logic susp;
    logic resume;
    logic rst;
    logic autosel;
    logic cfi;
  } req_t;

  localparam logic [7:0] CMD_UNL_A  = 8'hAA;
  localparam logic [7:0] CMD_UNL_B  = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ERASE  = 8'h80;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_SECT   = 8'h30;
  localparam logic [7:0] CMD_AUTO   = 8'h90;
  localparam logic [7:0] CMD_BYPASS = 8'h20;
  localparam logic [7:0] CMD_RESET  = 8'hF0;
  localparam logic [7:0] CMD_SUSP   = 8'hB0;
  localparam logic [7:0] CMD_QUERY  = 8'h98;
endpackage

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int BANK_W    = 2,
  parameter int UNLOCK_AW = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              done_i,
  output req_t              req_o,
  output mode_e             mode_o,
  output logic              susp_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o
);
  localparam logic [UNLOCK_AW-1:0] A_555 = UNLOCK_AW'('h555);
  localparam logic [UNLOCK_AW-1:0] A_2AA = UNLOCK_AW'('h2AA);
  localparam logic [UNLOCK_AW-1:0] A_055 = UNLOCK_AW'('h055);

  step_e step_q, step_d;
  mode_e mode_q, mode_d;
  req_t  req_q, req_d;
  logic  susp_q, susp_d, erase_q, erase_d, cap, bank_cap;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  logic [UNLOCK_AW-1:0] lo_a;
  logic [7:0] d8;
  logic is_555, is_2aa, is_055;
  assign lo_a   = addr_i[UNLOCK_AW-1:0];
  assign d8     = wdata_i[7:0];
  assign is_555 = (lo_a == A_555);
  assign is_2aa = (lo_a == A_2AA);
  assign is_055 = (lo_a == A_055);

  always_comb begin
    step_d = step_q; mode_d = mode_q; susp_d = susp_q; erase_d = erase_q;
    req_d = '0; cap = 1'b0; bank_cap = 1'b0;
    if (done_i && !susp_q) erase_d = 1'b0;
    if (wr_i) begin
      if (busy_i) begin
        if (d8 == CMD_SUSP && erase_q && !susp_q) begin
          req_d.susp = 1'b1; susp_d = 1'b1; step_d = ST_IDLE;
        end
      end else begin
        step_d = ST_IDLE;
        unique case (step_q)
          ST_IDLE: begin
            if (mode_q == MODE_BYPASS) begin
              if (d8 == CMD_PROG)       step_d = ST_PROG;
              else if (d8 == CMD_ERASE) step_d = ST_BERASE;
              else if (d8 == CMD_AUTO)  step_d = ST_BEXIT;
            end else if (d8 == CMD_RESET) begin
              req_d.rst = 1'b1; mode_d = MODE_READ;
            end else if (d8 == CMD_UNL_A && is_555) begin
              step_d = ST_UNL1;
            end else if (d8 == CMD_QUERY && is_055 && (mode_q == MODE_AUTOSEL || !susp_q)) begin
              req_d.cfi = 1'b1;
            end else if (d8 == CMD_SECT && susp_q) begin
              req_d.resume = 1'b1; susp_d = 1'b0;
            end else if (d8 == CMD_SUSP && erase_q && !susp_q) begin
              req_d.susp = 1'b1; susp_d = 1'b1;
            end
          end
          ST_UNL1: if (d8 == CMD_UNL_B && is_2aa) step_d = ST_UNL2;
          ST_UNL2: if (is_555) begin
            if (d8 == CMD_PROG) step_d = ST_PROG;
            else if (d8 == CMD_ERASE && !susp_q) step_d = ST_ER1;
            else if (d8 == CMD_AUTO) begin
              req_d.autosel = 1'b1; mode_d = MODE_AUTOSEL; bank_cap = 1'b1;
            end else if (d8 == CMD_BYPASS && mode_q == MODE_READ && !susp_q)
              mode_d = MODE_BYPASS;
          end
          ST_PROG: begin req_d.prog = 1'b1; cap = 1'b1; end
          ST_ER1:  if (d8 == CMD_UNL_A && is_555) step_d = ST_ER2;
          ST_ER2:  if (d8 == CMD_UNL_B && is_2aa) step_d = ST_ER3;
          ST_ER3: begin
            if (d8 == CMD_CHIP && is_555) req_d.chip = 1'b1;
            else if (d8 == CMD_SECT) begin
              req_d.sect = 1'b1; cap = 1'b1; erase_d = 1'b1;
            end
          end
          ST_BERASE: if (d8 == CMD_CHIP) req_d.chip = 1'b1;
          ST_BEXIT:  if (d8 == 8'h00) mode_d = MODE_READ;
          default: step_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_IDLE; mode_q <= MODE_READ; req_q <= '0;
      susp_q <= 1'b0; erase_q <= 1'b0; bank_q <= '0;
      addr_q <= '0; data_q <= '0;
    end else begin
      step_q <= step_d; mode_q <= mode_d; req_q <= req_d;
      susp_q <= susp_d; erase_q <= erase_d;
      if (bank_cap) bank_q <= addr_i[ADDR_W-1 -: BANK_W];
      if (cap) begin addr_q <= addr_i; data_q <= wdata_i; end
    end
  end

  assign req_o     = req_q;
  assign mode_o    = mode_q;
  assign susp_o    = susp_q;
  assign bank_o    = bank_q;
  assign op_addr_o = addr_q;
  assign op_data_o = data_q;

  // R13
  req_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(req_q));
  // R13
  prog_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) req_q.prog |=> !req_q.prog);
  // R7
  susp_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_d.susp |=> (susp_q && $past(erase_q) && !$past(susp_q)));
  // R12
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && wr_i && wdata_i[7:0] != CMD_SUSP) |=>
    !(req_q.prog || req_q.chip || req_q.sect || req_q.rst || req_q.cfi || req_q.autosel));
  // R10
  bypass_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_BYPASS && !(wr_i && !busy_i)) |=> mode_q == MODE_BYPASS);
  // R8
  cfi_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q.cfi |-> $past(mode_q) != MODE_BYPASS);
endmodule

// File: rtl/flash_id_table.sv
module flash_id_table
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int BANK_W = 2,
  parameter int SG_W   = 3,
  parameter logic [2**SG_W-1:0] PROT_MASK = 8'b1010_0110,
  parameter logic [DATA_W-1:0] MFR_ID  = 16'h0001,
  parameter logic [DATA_W-1:0] DEV_ID0 = 16'h22A5,
  parameter logic [DATA_W-1:0] DEV_ID1 = 16'h2210,
  parameter logic [DATA_W-1:0] DEV_ID2 = 16'h2203
) (
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  mode_e             mode_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [DATA_W-1:0] array_rdata_i,
  output logic              array_rd_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic hit;
  logic [SG_W-1:0] sg;
  logic [DATA_W-1:0] id_word;
  logic unused_addr;

  assign unused_addr = ^addr_i;
  assign sg  = addr_i[ADDR_W-1 -: SG_W];
  assign hit = (mode_i == MODE_AUTOSEL) && (addr_i[ADDR_W-1 -: BANK_W] == bank_i);

  always_comb begin
    unique case (addr_i[7:0])
      8'h00:   id_word = MFR_ID;
      8'h01:   id_word = DEV_ID0;
      8'h02:   id_word = DATA_W'(PROT_MASK[sg]);
      8'h0E:   id_word = DEV_ID1;
      8'h0F:   id_word = DEV_ID2;
      default: id_word = '0;
    endcase
  end

  assign array_rd_o = rd_i && !hit;
  assign rdata_o    = hit ? id_word : array_rdata_i;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int BANK_W    = 2,
  parameter int SG_W      = 3,
  parameter int UNLOCK_AW = 11,
  parameter logic [2**SG_W-1:0] PROT_MASK = 8'b1010_0110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] array_rdata_i,
  output logic              array_rd_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              prog_req_o,
  output logic              chip_erase_o,
  output logic              sector_erase_o,
  output logic              suspend_o,
  output logic              resume_o,
  output logic              reset_o,
  output logic              autosel_o,
  output logic              cfi_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic [1:0]        mode_o,
  output logic              suspended_o
);
  req_t  req;
  mode_e mode;
  logic [BANK_W-1:0] bank;

  flash_seq_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .UNLOCK_AW(UNLOCK_AW)
  ) u_fsm (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i, .busy_i, .done_i,
    .req_o(req), .mode_o(mode), .susp_o(suspended_o), .bank_o(bank),
    .op_addr_o, .op_data_o
  );

  flash_id_table #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .SG_W(SG_W), .PROT_MASK(PROT_MASK)
  ) u_id (
    .rd_i, .addr_i, .mode_i(mode), .bank_i(bank), .array_rdata_i,
    .array_rd_o, .rdata_o
  );

  assign prog_req_o     = req.prog;
  assign chip_erase_o   = req.chip;
  assign sector_erase_o = req.sect;
  assign suspend_o      = req.susp;
  assign resume_o       = req.resume;
  assign reset_o        = req.rst;
  assign autosel_o      = req.autosel;
  assign cfi_o          = req.cfi;
  assign mode_o         = mode;

  // R14
  read_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode != MODE_AUTOSEL) |-> (rdata_o == array_rdata_i && array_rd_o == rd_i));
  // R6
  reset_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_o |-> (mode == MODE_READ && suspended_o == $past(suspended_o)));
endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;
  localparam logic [7:0] PM = 8'b1010_0110;
  localparam logic [7:0] P_PROG = 8'h80, P_CHIP = 8'h40, P_SECT = 8'h20, P_SUSP = 8'h10,
                         P_RES = 8'h08, P_RST = 8'h04, P_AS = 8'h02, P_CFI = 8'h01;

  logic clk = 0, rst_ni = 0, wr_i = 0, rd_i = 0, busy_i = 0, done_i = 0;
  logic [15:0] addr_i = '0, wdata_i = '0, array_rdata_i = 16'hBEEF;
  logic array_rd_o, prog_req_o, chip_erase_o, sector_erase_o, suspend_o, resume_o;
  logic reset_o, autosel_o, cfi_o, suspended_o;
  logic [15:0] rdata_o, op_addr_o, op_data_o;
  logic [1:0] mode_o;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  flash_cmd_decoder dut (
    .clk_i(clk), .rst_ni, .wr_i, .rd_i, .addr_i, .wdata_i, .busy_i, .done_i,
    .array_rdata_i, .array_rd_o, .rdata_o, .prog_req_o, .chip_erase_o,
    .sector_erase_o, .suspend_o, .resume_o, .reset_o, .autosel_o, .cfi_o,
    .op_addr_o, .op_data_o, .mode_o, .suspended_o
  );

  function automatic logic [7:0] pv();
    return {prog_req_o, chip_erase_o, sector_erase_o, suspend_o, resume_o, reset_o, autosel_o, cfi_o};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_st(input string tag, input logic [7:0] p, input logic [1:0] m, input bit s);
    chk(pv() == p, {tag, " pulses"}, 32'(pv()), 32'(p));
    chk(mode_o == m, {tag, " mode"}, 32'(mode_o), 32'(m));
    chk(suspended_o == s, {tag, " susp"}, 32'(suspended_o), 32'(s));
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); wr_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk); wr_i = 0;
  endtask

  task automatic unlock();
    wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055);
  endtask

  function automatic logic [15:0] id_exp(input logic [7:0] o, input logic [2:0] sg);
    case (o)
      8'h00: return 16'h0001;
      8'h01: return 16'h22A5;
      8'h02: return {15'b0, PM[sg]};
      8'h0E: return 16'h2210;
      8'h0F: return 16'h2203;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state, R14 pass-through
    chk_st("R1", 8'h00, 2'd0, 0);
    rd_i = 1; #1;
    chk(rdata_o == 16'hBEEF && array_rd_o, "R14 read pass", 32'(rdata_o), 32'hBEEF);
    rd_i = 0;

    // R11 sweep all third-write codes
    for (int c = 0; c < 256; c++) begin
      unlock();
      wr(16'h0555, 16'(c));
      chk_st("R11 code sweep", (c == 8'h90) ? P_AS : 8'h00,
             (c == 8'h90) ? 2'd1 : (c == 8'h20) ? 2'd2 : 2'd0, 0);
      if (c == 8'hA0) begin
        wr(16'h1000 + 16'(c), 16'hC0DE);
        chk(prog_req_o && op_addr_o == 16'h10A0 && op_data_o == 16'hC0DE, "R3 program",
            {op_addr_o, op_data_o}, {16'h10A0, 16'hC0DE});
        @(negedge clk);
        chk(!prog_req_o, "R13 pulse width", 32'(prog_req_o), 0);
      end else if (c == 8'h80) begin
        wr(16'h0000, 16'h0000);
        chk_st("R11 abort erase", 8'h00, 2'd0, 0);
      end else if (c == 8'h90) begin
        wr(16'h0000, 16'h00F0);
        chk_st("R6 leave autoselect", P_RST, 2'd0, 0);
      end else if (c == 8'h20) begin
        wr(16'h0000, 16'h0090); wr(16'h0000, 16'h0000);
        chk_st("R10 exit bypass", 8'h00, 2'd0, 0);
      end
    end

    // R2 high bits ignored
    wr(16'hFD55, 16'h12AA); wr(16'hA2AA, 16'hFF55); wr(16'h7555, 16'h34A0);
    wr(16'h4321, 16'hABCD);
    chk(prog_req_o && op_addr_o == 16'h4321 && op_data_o == 16'hABCD, "R2 noisy unlock",
        {op_addr_o, op_data_o}, {16'h4321, 16'hABCD});
    // R11 wrong unlock address
    wr(16'h0455, 16'h00AA); wr(16'h02AA, 16'h0055); wr(16'h0555, 16'h00A0);
    wr(16'h1000, 16'h5555);
    chk_st("R11 bad unlock", 8'h00, 2'd0, 0);

    // R4 chip erase
    unlock(); wr(16'h0555, 16'h0080); unlock(); wr(16'h0555, 16'h0010);
    chk_st("R4 chip erase", P_CHIP, 2'd0, 0);
    // R12 busy ignores program and reset
    busy_i = 1;
    unlock(); wr(16'h0555, 16'h00A0); wr(16'h2000, 16'h1111);
    chk_st("R12 busy program", 8'h00, 2'd0, 0);
    wr(16'h0000, 16'h00F0);
    chk_st("R12 busy reset", 8'h00, 2'd0, 0);
    wr(16'h0000, 16'h00B0);
    chk_st("R7 no erase no suspend", 8'h00, 2'd0, 0);
    busy_i = 0;

    // R4 sector erase
    unlock(); wr(16'h0555, 16'h0080); unlock(); wr(16'h6000, 16'h0030);
    chk(sector_erase_o && op_addr_o == 16'h6000, "R4 sector erase", 32'(op_addr_o), 32'h6000);
    busy_i = 1;
    wr(16'hC000, 16'h00B0);
    chk_st("R7 suspend", P_SUSP, 2'd0, 1);
    busy_i = 0;
    wr(16'hC000, 16'h00B0);
    chk_st("R7 second suspend", 8'h00, 2'd0, 1);
    wr(16'h0055, 16'h0098);
    chk_st("R8 no query when suspended", 8'h00, 2'd0, 1);
    unlock(); wr(16'h0555, 16'h00A0); wr(16'h3456, 16'h7777);
    chk(prog_req_o && op_data_o == 16'h7777, "R3 program in suspend", 32'(op_data_o), 32'h7777);
    unlock(); wr(16'h0555, 16'h0020);
    chk_st("R9 no bypass when suspended", 8'h00, 2'd0, 1);
    unlock(); wr(16'h8555, 16'h0090);
    chk_st("R5 autoselect entry", P_AS, 2'd1, 1);

    // R5 autoselect read sweep
    rd_i = 1;
    for (int b = 0; b < 4; b++)
      for (int s = 0; s < 2; s++)
        for (int o = 0; o < 256; o++) begin
          logic [15:0] ex;
          addr_i = {2'(b), 1'(s), 5'b0, 8'(o)};
          #1;
          ex = (b == 2) ? id_exp(8'(o), {2'(b), 1'(s)}) : 16'hBEEF;
          chk(rdata_o == ex, "R5 id read", 32'(rdata_o), 32'(ex));
          chk(array_rd_o == (b != 2), "R14 array strobe", 32'(array_rd_o), 32'(b != 2));
        end
    rd_i = 0;

    wr(16'h0055, 16'h0098);
    chk_st("R8 query in autoselect", P_CFI, 2'd1, 1);
    wr(16'h1234, 16'h00F0);
    chk_st("R6 reset keeps suspend", P_RST, 2'd0, 1);
    wr(16'h0000, 16'h0030);
    chk_st("R7 resume", P_RES, 2'd0, 0);
    wr(16'h0000, 16'h0030);
    chk_st("R7 resume not suspended", 8'h00, 2'd0, 0);
    @(negedge clk); done_i = 1; @(negedge clk); done_i = 0;
    wr(16'h0000, 16'h00B0);
    chk_st("R7 erase finished", 8'h00, 2'd0, 0);
    wr(16'h0055, 16'h0098);
    chk_st("R8 query read-array", P_CFI, 2'd0, 0);
    wr(16'h0155, 16'h0098);
    chk_st("R8 query bad address", 8'h00, 2'd0, 0);

    // R9 bypass
    unlock(); wr(16'h0555, 16'h0020);
    chk_st("R9 bypass entry", 8'h00, 2'd2, 0);
    wr(16'h0000, 16'h00A0); wr(16'h2222, 16'h9999);
    chk(prog_req_o && op_addr_o == 16'h2222 && op_data_o == 16'h9999, "R9 bypass program",
        {op_addr_o, op_data_o}, {16'h2222, 16'h9999});
    wr(16'h0000, 16'h0080); wr(16'h0000, 16'h0010);
    chk_st("R9 bypass chip erase", P_CHIP, 2'd2, 0);
    wr(16'h0000, 16'h00F0);
    chk_st("R10 reset ignored in bypass", 8'h00, 2'd2, 0);
    wr(16'h0000, 16'h0090); wr(16'h0000, 16'h0001);
    chk_st("R10 bad exit", 8'h00, 2'd2, 0);
    wr(16'h0000, 16'h0090); wr(16'h0000, 16'h0000);
    chk_st("R10 exit", 8'h00, 2'd0, 0);

    finished = 1;
    finish_run();
  end
endmodule